// File: doc/BRIEF.md
# Real-Time-Clock Status and Alarm Interrupt Register

This block is one byte of control and status for a real-time-clock device. It is reached through a simple synchronous register port with an address, a write strobe, write data and combinational read data. The byte brings together fields that behave in different ways. One flag records that the oscillator stopped. One flag is raised by the temperature-conversion handshake. Two flags record alarm matches. These flags are set by hardware and software can only clear them. One software-owned bit enables the 32.768 kHz clock output.

The oscillator, the alarm comparators, the temperature sensor and the host serial link sit outside the block. Their events arrive as single-cycle pulses. The block combines the alarm flags with per-alarm interrupt enables and an interrupt-mode select, and drives an active-low interrupt request. A host clears an alarm by writing a byte with 0 in that alarm's position and 1 in every other flag position. Flags it does not mean to touch stay as they are.

Top module: `rtc_status_reg`

## Requirements
- R1: After reset the status byte reads 0x88: the oscillator-stop flag is 1, the clock-output enable is 1, and busy and both alarm flags are 0.
- R2: Bit 7, the oscillator-stop flag, goes to 1 in the cycle after an `osc_stop_evt` pulse. It stays 1 until a write to the status address carries 0 in bit 7. A write carrying 1 in bit 7 leaves the flag unchanged.
- R3: Bits 6 to 4 always read 0, and writing 1 to them has no effect on the read value.
- R4: Bit 3 is a read/write clock-output enable. `sq_oe` equals bit 3. `sq_out` follows `sq_in` only while bit 3 is 1 and `osc_en` is 1, and is 0 otherwise.
- R5: Bit 2, busy, becomes 1 after a `conv_start` pulse and 0 after a `conv_done` pulse. When both arrive in the same cycle, busy becomes 1. Writes never change busy.
- R6: Bit 1 (alarm 2) is set by `alarm_hit[1]`. Bit 0 (alarm 1) is set by `alarm_hit[0]`. Each flag is 1 in the cycle after its pulse.
- R7: An alarm flag is cleared only by a status write with 0 in its bit position. A write with 1 there leaves the flag as it was.
- R8: When a hardware set of a flag and a software clear of the same flag fall in the same cycle, the flag ends at 1.
- R9: `irq_n` is low exactly when `irq_mode_sel` is 1 and, for some alarm n, flag n and `alarm_ie[n]` are both 1. `irq_n` is combinational from that state, so it returns high in the cycle after the last contributing flag is cleared.
- R10: A read from any other address returns 0. A write to any other address changes nothing.
- R11: `bus_rdata` shows the register contents for the current address combinationally. A write becomes visible on read after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| osc_stop_evt | input | 1 | Pulse: oscillator stop detected |
| conv_start | input | 1 | Pulse: temperature conversion started |
| conv_done | input | 1 | Pulse: temperature conversion finished |
| alarm_hit | input | 2 | Pulses: bit 0 alarm 1 match, bit 1 alarm 2 match |
| alarm_ie | input | 2 | Per-alarm interrupt enables, same bit order |
| irq_mode_sel | input | 1 | 1 routes alarm flags to the interrupt pin |
| osc_en | input | 1 | Oscillator running |
| sq_in | input | 1 | 32.768 kHz square wave from the oscillator |
| sq_oe | output | 1 | Drive enable for the clock output pin |
| sq_out | output | 1 | Gated square wave |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets the cycle in which a hardware set and a software clear of the same flag coincide. A design that let the clear win would lose an alarm or an oscillator stop. It writes 1 to every flag position and expects no change, which catches a design that treats the flags as plain read/write bits. It drives conversion start and done in the same cycle, and writes to bits 6 to 4 and to foreign addresses, to expose a busy bit with the wrong priority, reserved bits that keep data, or a weak address decode. It also sweeps the interrupt enables and the mode select against the flags to find a wrong gating term or a registered (one-cycle-late) `irq_n`.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
    localparam int STAT_W   = 8;
    localparam int N_ALARM  = 2;
    localparam int BIT_OSF  = 7;
    localparam int BIT_EN   = 3;
    localparam int BIT_BUSY = 2;
    localparam int NFLAG    = N_ALARM + 1;
    // bits software may write; all others are hardware-owned or reserved
    localparam logic [STAT_W-1:0] WR_MASK = 8'h8B;
    localparam logic [STAT_W-1:0] RST_BYTE = 8'h88;
endpackage

// File: rtl/rtc_sticky_flags.sv
module rtc_sticky_flags #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] nxt;

    // set has priority over clear so that no event is dropped
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign nxt[g] = set_i[g] | (st_q.flag[g] & ~clr_i[g]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.flag <= RST_VAL;
        else        st_q      <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/rtc_busy_track.sv
module rtc_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o
);
    typedef struct packed {
        logic busy;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)     st_d.busy = 1'b1;
        else if (done_i) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.busy <= 1'b0;
        else        st_q      <= st_d;
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
    parameter int N = 2
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] ie_i,
    input  logic         mode_i,
    output logic         irq_n_o
);
    logic [N-1:0] term;

    for (genvar g = 0; g < N; g++) begin : g_term
        assign term[g] = flag_i[g] & ie_i[g];
    end

    assign irq_n_o = ~(mode_i & (|term));
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
    import rtc_stat_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'hF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [STAT_W-1:0]   bus_wdata,
    output logic [STAT_W-1:0]   bus_rdata,
    input  logic                osc_stop_evt,
    input  logic                conv_start,
    input  logic                conv_done,
    input  logic [N_ALARM-1:0]  alarm_hit,
    input  logic [N_ALARM-1:0]  alarm_ie,
    input  logic                irq_mode_sel,
    input  logic                osc_en,
    input  logic                sq_in,
    output logic                sq_oe,
    output logic                sq_out,
    output logic                irq_n
);
    typedef struct packed {
        logic en32;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                sel;
    logic                wr;
    logic [STAT_W-1:0]   wr_val;
    logic [NFLAG-1:0]    flag_set;
    logic [NFLAG-1:0]    flag_clr;
    logic [NFLAG-1:0]    flag_q;
    logic                osf_q;
    logic                busy_q;
    logic [N_ALARM-1:0]  alm_q;
    logic                en32_q;
    logic [STAT_W-1:0]   rd_byte;

    assign sel    = (bus_addr == STAT_ADDR);
    assign wr     = bus_we & sel;
    assign wr_val = bus_wdata & WR_MASK;

    // flag vector: top bit oscillator stop, low bits alarms
    assign flag_set = {osc_stop_evt, alarm_hit};
    assign flag_clr = wr ? ~{wr_val[BIT_OSF], wr_val[N_ALARM-1:0]} : '0;

    rtc_sticky_flags #(
        .N       (NFLAG),
        .RST_VAL ({1'b1, {N_ALARM{1'b0}}})
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    assign osf_q = flag_q[NFLAG-1];
    assign alm_q = flag_q[N_ALARM-1:0];

    rtc_busy_track u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .done_i  (conv_done),
        .busy_o  (busy_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr) ctl_d.en32 = wr_val[BIT_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.en32 <= RST_BYTE[BIT_EN];
        else        ctl_q      <= ctl_d;
    end

    assign en32_q = ctl_q.en32;

    rtc_irq_gen #(.N(N_ALARM)) u_irq (
        .flag_i  (alm_q),
        .ie_i    (alarm_ie),
        .mode_i  (irq_mode_sel),
        .irq_n_o (irq_n)
    );

    always_comb begin
        rd_byte                 = '0;
        rd_byte[BIT_OSF]        = osf_q;
        rd_byte[BIT_EN]         = en32_q;
        rd_byte[BIT_BUSY]       = busy_q;
        rd_byte[N_ALARM-1:0]    = alm_q;
    end

    assign bus_rdata = sel ? rd_byte : '0;
    assign sq_oe     = en32_q;
    assign sq_out    = sq_in & en32_q & osc_en;
endmodule

// File: rtl/rtc_status_chk.sv
module rtc_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic [7:0] bus_wdata,
    input logic       osc_stop_evt,
    input logic       conv_start,
    input logic       conv_done,
    input logic [1:0] alarm_hit,
    input logic [1:0] alarm_ie,
    input logic       irq_mode_sel,
    input logic       osf_q,
    input logic       busy_q,
    input logic [1:0] alm_q,
    input logic       en32_q,
    input logic       irq_n
);
    a_r2_osf_set: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_evt |=> osf_q);
    a_r2_osf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (osf_q && !(wr && !bus_wdata[7])) |=> osf_q);
    a_r4_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en32_q == $past(bus_wdata[3])));
    a_r5_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy_q);
    a_r5_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !conv_start) |=> !busy_q);
    a_r6_alm_set: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit[0] |=> alm_q[0]);
    a_r7_alm_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_q[0] && !(wr && !bus_wdata[0])) |=> alm_q[0]);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit[1] && wr && !bus_wdata[1]) |=> alm_q[1]);
    a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_sel && alm_q[0] && alarm_ie[0]) |-> !irq_n);
    a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mode_sel |-> irq_n);
endmodule

bind rtc_status_reg rtc_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (wr),
    .bus_wdata    (bus_wdata),
    .osc_stop_evt (osc_stop_evt),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .alarm_hit    (alarm_hit),
    .alarm_ie     (alarm_ie),
    .irq_mode_sel (irq_mode_sel),
    .osf_q        (osf_q),
    .busy_q       (busy_q),
    .alm_q        (alm_q),
    .en32_q       (en32_q),
    .irq_n        (irq_n)
);

// File: tb/test_rtc_status_reg.sv
module test_rtc_status_reg;
    localparam logic [4:0] ST = 5'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = ST;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       osc_stop_evt = 1'b0, conv_start = 1'b0, conv_done = 1'b0;
    logic [1:0] alarm_hit = 2'b00, alarm_ie = 2'b00;
    logic       irq_mode_sel = 1'b0, osc_en = 1'b0, sq_in = 1'b0;
    logic       sq_oe, sq_out, irq_n;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "R1 reset";

    // behavioural reference state
    bit m_osf, m_en, m_busy, m_a2, m_a1;

    always #10 clk = ~clk;

    rtc_status_reg i_rtc_status_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_stop_evt(osc_stop_evt),
        .conv_start(conv_start), .conv_done(conv_done), .alarm_hit(alarm_hit),
        .alarm_ie(alarm_ie), .irq_mode_sel(irq_mode_sel), .osc_en(osc_en),
        .sq_in(sq_in), .sq_oe(sq_oe), .sq_out(sq_out), .irq_n(irq_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_osf <= 1; m_en <= 1; m_busy <= 0; m_a2 <= 0; m_a1 <= 0;
        end else begin
            bit w;
            w = bus_we && (bus_addr == ST);
            m_osf <= osc_stop_evt || (m_osf && !(w && !bus_wdata[7]));
            m_a2  <= alarm_hit[1] || (m_a2 && !(w && !bus_wdata[1]));
            m_a1  <= alarm_hit[0] || (m_a1 && !(w && !bus_wdata[0]));
            if (w) m_en <= bus_wdata[3];
            if (conv_start) m_busy <= 1;
            else if (conv_done) m_busy <= 0;
        end
    end

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            logic [7:0] e_rd;
            logic       e_irq;
            e_rd  = (bus_addr == ST) ? {m_osf, 3'b000, m_en, m_busy, m_a2, m_a1} : 8'h00;
            e_irq = !(irq_mode_sel && ((m_a1 && alarm_ie[0]) || (m_a2 && alarm_ie[1])));
            check("rdata", bus_rdata, e_rd);
            check("irq_n", {7'd0, irq_n}, {7'd0, e_irq});
            check("sq_oe", {7'd0, sq_oe}, {7'd0, m_en});
            check("sq_out", {7'd0, sq_out}, {7'd0, sq_in & m_en & osc_en});
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [4:0] a, input logic [7:0] v);
        bus_addr = a; bus_we = 1; bus_wdata = v;
        cyc();
        bus_we = 0; bus_addr = ST;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            done = 1;
            summary();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1: explicit reset value check
        total++;
        if (bus_rdata !== 8'h88) begin
            bad++;
            $display("FAIL R1 reset byte: actual=%h expected=88", bus_rdata);
        end
        cyc(2);

        phase = "R2 osc stop flag";
        wr_byte(ST, 8'h08); cyc();
        osc_stop_evt = 1; cyc(); osc_stop_evt = 0; cyc();
        wr_byte(ST, 8'h88); cyc();
        wr_byte(ST, 8'h8B); cyc();
        wr_byte(ST, 8'h08); cyc();

        phase = "R3 reserved bits";
        wr_byte(ST, 8'hF8); cyc();
        wr_byte(ST, 8'h78); cyc();

        phase = "R4 clock enable";
        osc_en = 1; sq_in = 1; cyc();
        wr_byte(ST, 8'h00); sq_in = 0; cyc(); sq_in = 1; cyc();
        wr_byte(ST, 8'h08); cyc(); osc_en = 0; cyc(); osc_en = 1; sq_in = 0; cyc();

        phase = "R5 busy";
        conv_start = 1; cyc(); conv_start = 0; cyc(2);
        wr_byte(ST, 8'h08); cyc();
        conv_done = 1; cyc(); conv_done = 0; cyc();
        wr_byte(ST, 8'h0C); cyc();
        conv_start = 1; conv_done = 1; cyc(); conv_start = 0; conv_done = 0; cyc();
        conv_done = 1; cyc(); conv_done = 0; cyc();

        phase = "R6 alarm set";
        alarm_hit = 2'b01; cyc(); alarm_hit = 2'b00; cyc();
        alarm_hit = 2'b10; cyc(); alarm_hit = 2'b00; cyc();

        phase = "R7 alarm clear";
        wr_byte(ST, 8'h8B); cyc();
        wr_byte(ST, 8'h0A); cyc();
        wr_byte(ST, 8'h09); cyc();

        phase = "R8 set beats clear";
        alarm_hit = 2'b11; osc_stop_evt = 1;
        wr_byte(ST, 8'h08);
        alarm_hit = 2'b00; osc_stop_evt = 0; cyc();
        wr_byte(ST, 8'h08); cyc();

        phase = "R9 interrupt";
        alarm_hit = 2'b01; cyc(); alarm_hit = 2'b00;
        for (int k = 0; k < 8; k++) begin
            alarm_ie = k[1:0]; irq_mode_sel = k[2]; cyc();
        end
        alarm_hit = 2'b10; cyc(); alarm_hit = 2'b00;
        for (int k = 0; k < 8; k++) begin
            alarm_ie = k[1:0]; irq_mode_sel = k[2]; cyc();
        end
        alarm_ie = 2'b11; irq_mode_sel = 1; cyc();
        wr_byte(ST, 8'h0A); cyc();
        wr_byte(ST, 8'h08); cyc(2);

        phase = "R10 other address";
        alarm_hit = 2'b11; cyc(); alarm_hit = 2'b00;
        wr_byte(5'h0E, 8'h00); cyc();
        wr_byte(5'h1F, 8'h00); cyc();
        bus_addr = 5'h0E; cyc(); bus_addr = 5'h07; cyc(); bus_addr = ST; cyc();

        phase = "R11 random traffic";
        for (int i = 0; i < 600; i++) begin
            bus_we       = ($urandom_range(0, 7) == 0);
            bus_addr     = ($urandom_range(0, 3) == 0) ? 5'($urandom) : ST;
            bus_wdata    = 8'($urandom);
            osc_stop_evt = ($urandom_range(0, 31) == 0);
            conv_start   = ($urandom_range(0, 15) == 0);
            conv_done    = ($urandom_range(0, 15) == 0);
            alarm_hit[0] = ($urandom_range(0, 19) == 0);
            alarm_hit[1] = ($urandom_range(0, 19) == 0);
            alarm_ie     = 2'($urandom);
            irq_mode_sel = 1'($urandom);
            osc_en       = 1'($urandom);
            sq_in        = 1'($urandom);
            cyc();
        end
        bus_we = 0; osc_stop_evt = 0; conv_start = 0; conv_done = 0; alarm_hit = 0;
        bus_addr = ST;
        cyc(2);
        done = 1;
        summary();
    end
endmodule